// File: doc/BRIEF.md
# MSK Tone Modulator

This block turns a stream of bytes into a digital minimum-shift-keyed transmit waveform at 1200 baud. Each bit is sent as one of two tones: 1200 Hz for a logic 1 and 1800 Hz for a logic 0. A phase accumulator advances once per sample tick (`smp_en`, an enable that the system clock domain supplies at `SMP_HZ`). It selects its step from the bit currently on the line. The top bits of the phase feed a computed half-wave shaping function that produces two's-complement sample codes.

The tone changes only at bit boundaries, and the accumulator value carries across them unchanged. The waveform therefore has no phase step. Because 1200 baud is exactly one cycle of the lower tone and one and a half cycles of the upper tone, the result is phase-continuous two-tone keying.

Software-side logic hands over bytes through a one-byte holding register with a valid/ready handshake. Bytes are shifted out MSB first. `out_en` stands in for the driver of a line that floats when idle. It rises when a byte is loaded. It falls one full bit period after the last queued bit has gone out, and during that bit period the output rests at the mid-scale code. A general-reset command (`gen_reset`) forces the output to mid-scale, releases the line and clears the holding register and the phase.

Top module: `msk_tone_mod`

## Requirements
- R1: After `rst_n` is released, `out_en` is 0, `sample_out` is 0, `tx_ready` is 1, `bit_end` and `tone_wrap` are 0, and the accumulator phase is 0.
- R2: While a 1 bit is sent, the 16-bit (ACC_W) accumulator grows by 1200*2^ACC_W/SMP_HZ on every `smp_en` tick. `tone_wrap` pulses for one cycle after each tick on which the accumulator overflows.
- R3: While a 0 bit is sent, the accumulator grows by 1800*2^ACC_W/SMP_HZ per tick, with the same `tone_wrap` behaviour.
- R4: The accumulator is never cleared at a bit boundary or between bytes, so the overflow count of every bit follows from the running phase total since the last reset.
- R5: Bits of a byte go out MSB first. `line_bit` shows the bit currently being sent.
- R6: `tx_ready` is 1 exactly when the holding register is empty, and a byte is taken on a cycle with `tx_valid` and `tx_ready` both 1. A held byte follows the previous byte with no idle bit. This holds even when it is written on the very cycle that ends the previous byte's last bit, and in both cases `out_en` stays 1.
- R7: `out_en` goes to 1 when a byte is loaded. After the `bit_end` of the last queued bit it stays 1 for exactly SPB = SMP_HZ/1200 further ticks, then falls.
- R8: `sample_out` is 0 (the mid-scale bias code) whenever `out_en` is 0 and during the trailing bit period.
- R9: A `gen_reset` cycle makes `out_en` 0, `sample_out` 0 and `tx_ready` 1 from the next cycle on, discards the shifting and held bytes and zeroes the phase. A write in the same cycle is dropped.
- R10: Each bit lasts exactly SPB `smp_en` ticks. `bit_end` is a one-cycle pulse in the cycle after the tick that ends a bit.
- R11: Sample codes are two's complement within ±(2^(SMP_W-1)-1) and reach both full-scale extremes during a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample tick enable at SMP_HZ |
| gen_reset | input | 1 | Synchronous general-reset command |
| tx_data | input | BYTE_W | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding register empty; byte accepted when valid |
| line_bit | output | 1 | Bit currently on the line |
| bit_end | output | 1 | One-cycle pulse after the last tick of a bit |
| tone_wrap | output | 1 | One-cycle pulse after an accumulator overflow |
| out_en | output | 1 | Line driven (0 models the floating output) |
| sample_out | output | SMP_W | Signed sample code, 0 = mid-scale bias |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is the final tick of a byte's last bit and a write into the empty holding register. The bench counts ticks since the previous `bit_end` and raises `tx_valid` only for the edge that carries the ending tick. It then expects the new byte's bits to follow after exactly SPB ticks, with `out_en` never dropping and no tail period.

The second pair is `gen_reset` and a write in the same cycle. The bench judges this by `tx_ready` staying 1 and the line staying released for several bit periods. A later byte must then start from phase zero in the bench's own overflow model.

// File: rtl/msk_pkg.sv
package msk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_TAIL = 2'd2
  } tx_state_e;

  // Phase increment per sample tick for a tone of f_hz at sample rate fs_hz.
  function automatic logic [31:0] tone_step(input longint f_hz, input longint fs_hz,
                                            input int acc_w);
    longint num;
    num = f_hz << acc_w;
    return 32'(num / fs_hz);
  endfunction

  // Half-wave parabolic shaping of a pw-bit phase into a signed code of
  // peak amp: positive in the first half of the cycle, negative in the second.
  function automatic int shape_code(input logic [15:0] ph, input int pw, input int amp);
    longint n;
    longint x;
    longint mag;
    logic   neg_half;
    n        = longint'(1) << (pw - 1);
    neg_half = ph[pw-1];
    x        = longint'(ph) & (n - 1);
    mag      = (4 * x * (n - x) * longint'(amp)) / (n * n);
    return neg_half ? -int'(mag) : int'(mag);
  endfunction

endpackage

// File: rtl/msk_bit_sequencer.sv
module msk_bit_sequencer
  import msk_pkg::*;
#(
  parameter int SPB    = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_reset,
  input  logic              smp_en,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output tx_state_e         state_o,
  output logic              adv_o,
  output logic              line_bit,
  output logic              bit_end
);
  localparam int CNT_W = (SPB > 1) ? $clog2(SPB) : 1;
  localparam int BL_W  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] TICK_LAST = CNT_W'(SPB - 1);
  localparam logic [BL_W-1:0]  BITS_AFTER_FIRST = BL_W'(BYTE_W - 1);

  tx_state_e         state_q;
  logic [BYTE_W-1:0] hold_q;
  logic              hold_full_q;
  logic [BYTE_W-1:0] shift_q;
  logic [BL_W-1:0]   bits_left_q;
  logic [CNT_W-1:0]  tick_q;
  logic              bit_end_q;

  logic accept;
  logic last_tick;
  logic send_tick;

  assign accept    = tx_valid && !hold_full_q && !gen_reset;
  assign last_tick = smp_en && (tick_q == TICK_LAST);
  assign send_tick = smp_en && (state_q == ST_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      shift_q     <= '0;
      bits_left_q <= '0;
      tick_q      <= '0;
      bit_end_q   <= 1'b0;
    end else if (gen_reset) begin
      state_q     <= ST_IDLE;
      hold_full_q <= 1'b0;
      shift_q     <= '0;
      bits_left_q <= '0;
      tick_q      <= '0;
      bit_end_q   <= 1'b0;
    end else begin
      bit_end_q <= 1'b0;
      if (accept) begin
        hold_q      <= tx_data;
        hold_full_q <= 1'b1;
      end
      unique case (state_q)
        ST_IDLE, ST_TAIL: begin
          if (hold_full_q) begin
            shift_q     <= hold_q;
            hold_full_q <= 1'b0;
            bits_left_q <= BITS_AFTER_FIRST;
            tick_q      <= '0;
            state_q     <= ST_SEND;
          end else if (state_q == ST_TAIL && smp_en) begin
            if (last_tick) begin
              tick_q  <= '0;
              state_q <= ST_IDLE;
            end else begin
              tick_q <= tick_q + 1'b1;
            end
          end
        end
        ST_SEND: begin
          if (smp_en) begin
            if (last_tick) begin
              bit_end_q <= 1'b1;
              tick_q    <= '0;
              if (bits_left_q != '0) begin
                shift_q     <= {shift_q[BYTE_W-2:0], 1'b0};
                bits_left_q <= bits_left_q - 1'b1;
              end else if (hold_full_q) begin
                shift_q     <= hold_q;
                hold_full_q <= 1'b0;
                bits_left_q <= BITS_AFTER_FIRST;
              end else begin
                state_q <= ST_TAIL;
              end
            end else begin
              tick_q <= tick_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_ready = !hold_full_q;
  assign state_o  = state_q;
  assign adv_o    = send_tick;
  assign line_bit = shift_q[BYTE_W-1];
  assign bit_end  = bit_end_q;

endmodule

// File: rtl/msk_phase_nco.sv
module msk_phase_nco #(
  parameter int               ACC_W      = 16,
  parameter logic [ACC_W-1:0] STEP_MARK  = 16'd1024,
  parameter logic [ACC_W-1:0] STEP_SPACE = 16'd1536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_reset,
  input  logic             adv,
  input  logic             bit_val,
  output logic [ACC_W-1:0] phase_o,
  output logic             wrap_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step;
  logic [ACC_W:0]   sum;
  logic             wrap_q;

  assign step = bit_val ? STEP_MARK : STEP_SPACE;
  assign sum  = {1'b0, acc_q} + {1'b0, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      wrap_q <= 1'b0;
    end else if (gen_reset) begin
      acc_q  <= '0;
      wrap_q <= 1'b0;
    end else if (adv) begin
      acc_q  <= sum[ACC_W-1:0];
      wrap_q <= sum[ACC_W];
    end else begin
      wrap_q <= 1'b0;
    end
  end

  assign phase_o = acc_q;
  assign wrap_o  = wrap_q;

endmodule

// File: rtl/msk_sine_shaper.sv
module msk_sine_shaper
  import msk_pkg::*;
#(
  parameter int PH_W  = 8,
  parameter int SMP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    adv,
  input  logic [PH_W-1:0]         phase_hi,
  output logic signed [SMP_W-1:0] code_o
);
  localparam int AMP = (1 << (SMP_W - 1)) - 1;

  logic signed [SMP_W-1:0] code_q;
  logic signed [SMP_W-1:0] code_next;

  assign code_next = SMP_W'(shape_code(16'(phase_hi), PH_W, AMP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (clr)    code_q <= '0;
    else if (adv)    code_q <= code_next;
  end

  assign code_o = code_q;

endmodule

// File: rtl/msk_tone_mod.sv
module msk_tone_mod
  import msk_pkg::*;
#(
  parameter int SMP_HZ   = 76800,
  parameter int BAUD_HZ  = 1200,
  parameter int MARK_HZ  = 1200,
  parameter int SPACE_HZ = 1800,
  parameter int ACC_W    = 16,
  parameter int PH_W     = 8,
  parameter int SMP_W    = 8,
  parameter int BYTE_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic                    gen_reset,
  input  logic [BYTE_W-1:0]       tx_data,
  input  logic                    tx_valid,
  output logic                    tx_ready,
  output logic                    line_bit,
  output logic                    bit_end,
  output logic                    tone_wrap,
  output logic                    out_en,
  output logic signed [SMP_W-1:0] sample_out
);
  localparam int SPB = SMP_HZ / BAUD_HZ;
  localparam logic [ACC_W-1:0] STEP_MARK  = ACC_W'(tone_step(MARK_HZ, SMP_HZ, ACC_W));
  localparam logic [ACC_W-1:0] STEP_SPACE = ACC_W'(tone_step(SPACE_HZ, SMP_HZ, ACC_W));

  tx_state_e               state;
  logic                    adv;
  logic [ACC_W-1:0]        phase;
  logic signed [SMP_W-1:0] code;
  logic                    sending;

  msk_bit_sequencer #(.SPB(SPB), .BYTE_W(BYTE_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_reset(gen_reset),
    .smp_en   (smp_en),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .state_o  (state),
    .adv_o    (adv),
    .line_bit (line_bit),
    .bit_end  (bit_end)
  );

  msk_phase_nco #(.ACC_W(ACC_W), .STEP_MARK(STEP_MARK), .STEP_SPACE(STEP_SPACE)) u_nco (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_reset(gen_reset),
    .adv      (adv),
    .bit_val  (line_bit),
    .phase_o  (phase),
    .wrap_o   (tone_wrap)
  );

  assign sending = (state == ST_SEND);

  msk_sine_shaper #(.PH_W(PH_W), .SMP_W(SMP_W)) u_shape (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (gen_reset || !sending),
    .adv     (adv),
    .phase_hi(phase[ACC_W-1 -: PH_W]),
    .code_o  (code)
  );

  assign out_en     = (state != ST_IDLE);
  assign sample_out = sending ? code : '0;

endmodule

// File: rtl/msk_tone_mod_chk.sv
module msk_tone_mod_chk #(
  parameter int SMP_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_en,
  input logic                    gen_reset,
  input logic                    tx_valid,
  input logic                    tx_ready,
  input logic                    bit_end,
  input logic                    tone_wrap,
  input logic                    out_en,
  input logic signed [SMP_W-1:0] sample_out
);
  localparam int AMP = (1 << (SMP_W - 1)) - 1;

  AST_IDLE_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (sample_out == '0)); // R8

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    gen_reset |=> (!out_en && tx_ready)); // R9

  AST_WRAP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tone_wrap |-> $past(smp_en)); // R2

  AST_BIT_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> ($past(smp_en) && out_en)); // R10

  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !gen_reset) |=> !tx_ready); // R6

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sample_out) <= AMP) && (int'(sample_out) >= -AMP)); // R11

endmodule

bind msk_tone_mod msk_tone_mod_chk #(.SMP_W(SMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_en    (smp_en),
  .gen_reset (gen_reset),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .bit_end   (bit_end),
  .tone_wrap (tone_wrap),
  .out_en    (out_en),
  .sample_out(sample_out)
);

// File: tb/msk_tone_mod_tb_top.sv
`timescale 1ns/1ps
module msk_tone_mod_tb_top;
  localparam int FS    = 76800;
  localparam int SPB   = FS / 1200;
  localparam int AMP   = 127;
  localparam longint STEP1 = (longint'(1200) << 16) / FS;
  localparam longint STEP0 = (longint'(1800) << 16) / FS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_en = 1'b0;
  logic              gen_reset = 1'b0;
  logic [7:0]        tx_data = '0;
  logic              tx_valid = 1'b0;
  logic              tx_ready;
  logic              line_bit;
  logic              bit_end;
  logic              tone_wrap;
  logic              out_en;
  logic signed [7:0] sample_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench-side model state
  bit     exp_bits[$];
  longint model_phase = 0;
  int     wrap_cnt = 0;
  int     tick_since = 0;
  int     tail_ticks = 0;
  bit     have_prev = 0;
  bit     in_tail = 0;
  bit     prev_line = 0;
  bit     prev_out_en = 0;
  int     bits_seen = 0;
  int     falls = 0;
  int     smin = 0;
  int     smax = 0;

  always #10 clk = ~clk;  // 50 MHz

  msk_tone_mod #(.SMP_HZ(FS), .BAUD_HZ(1200), .MARK_HZ(1200), .SPACE_HZ(1800),
                 .ACC_W(16), .PH_W(8), .SMP_W(8), .BYTE_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .gen_reset(gen_reset),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .line_bit(line_bit), .bit_end(bit_end), .tone_wrap(tone_wrap),
    .out_en(out_en), .sample_out(sample_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // sample tick every 4 clocks
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 4;
      smp_en = (div == 0);
    end
  end

  // monitor: sampled 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (gen_reset) begin
        exp_bits.delete();
        model_phase = 0;
        wrap_cnt = 0; tick_since = 0; tail_ticks = 0;
        have_prev = 0; in_tail = 0;
      end else begin
        if (smp_en) begin tick_since++; tail_ticks++; end
        if (tone_wrap) wrap_cnt++;
        if (bit_end) begin
          bits_seen++;
          if (exp_bits.size() == 0) begin
            chk(0, "R5 unexpected bit", 1, 0);
          end else begin
            bit     b;
            longint oldp;
            longint expw;
            b    = exp_bits.pop_front();
            chk(prev_line == b, "R5 bit order", prev_line, b);
            oldp = model_phase;
            model_phase += (b ? STEP1 : STEP0) * SPB;
            expw = (model_phase >> 16) - (oldp >> 16);
            if ((oldp % 65536) != 0) chk(wrap_cnt == expw, "R4 phase carry", wrap_cnt, expw);
            else if (b)              chk(wrap_cnt == expw, "R2 mark tone", wrap_cnt, expw);
            else                     chk(wrap_cnt == expw, "R3 space tone", wrap_cnt, expw);
          end
          wrap_cnt = 0;
          if (have_prev) chk(tick_since == SPB, "R10 bit length", tick_since, SPB);
          have_prev = 1;
          tick_since = 0;
          in_tail = (exp_bits.size() == 0);
          tail_ticks = 0;
        end
        if (in_tail && out_en && !bit_end)
          chk(sample_out == 0, "R8 tail bias", sample_out, 0);
        if (prev_out_en && !out_en) begin
          falls++;
          if (in_tail) chk(tail_ticks == SPB, "R7 tail length", tail_ticks, SPB);
          else         chk(0, "R7 early release", 0, 1);
          in_tail = 0;
          have_prev = 0;
        end
        if (!out_en) chk(sample_out == 0, "R8 idle bias", sample_out, 0);
        if (out_en) begin
          if (sample_out < smin) smin = sample_out;
          if (sample_out > smax) smax = sample_out;
        end
      end
      prev_line   = line_bit;
      prev_out_en = out_en;
    end
  end

  task automatic send_byte(input logic [7:0] d);
    int guard = 0;
    @(negedge clk);
    while (!tx_ready && guard < 20000) begin @(negedge clk); guard++; end
    tx_data  = d;
    tx_valid = 1'b1;
    for (int i = 7; i >= 0; i--) exp_bits.push_back(d[i]);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while ((out_en || exp_bits.size() != 0) && guard < 40000) begin @(negedge clk); guard++; end
    chk(!out_en, "R7 line released", out_en, 0);
  endtask

  task automatic pulse_reset(input bit with_write, input logic [7:0] d);
    @(negedge clk);
    gen_reset = 1'b1;
    tx_valid  = with_write;
    tx_data   = d;
    @(negedge clk);
    gen_reset = 1'b0;
    tx_valid  = 1'b0;
  endtask

  task automatic t_reset_state();
    chk(out_en == 0, "R1 out_en", out_en, 0);
    chk(sample_out == 0, "R1 sample", sample_out, 0);
    chk(tx_ready == 1, "R1 tx_ready", tx_ready, 1);
    chk(bit_end == 0 && tone_wrap == 0, "R1 pulses", {bit_end, tone_wrap}, 0);
  endtask

  task automatic t_single(input logic [7:0] d);
    send_byte(d);
    wait_idle();
  endtask

  task automatic t_back_to_back();
    int f0 = falls;
    send_byte(8'hA5);
    repeat (8) @(negedge clk);
    chk(tx_ready == 1 && out_en == 1, "R6 ready while sending", {tx_ready, out_en}, 3);
    send_byte(8'h3C);
    chk(tx_ready == 0, "R6 held byte blocks", tx_ready, 0);
    wait_idle();
    chk(falls == f0 + 1, "R6 no gap", falls - f0, 1);
  endtask

  task automatic t_write_on_last_tick();
    int f0 = falls;
    int b0;
    int guard = 0;
    send_byte(8'hC3);
    b0 = bits_seen;
    while (bits_seen < b0 + 7 && guard < 20000) begin @(negedge clk); guard++; end
    while (tick_since != SPB - 1 && guard < 20000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    chk(tx_ready == 1, "R6 ready at boundary", tx_ready, 1);
    tx_data  = 8'h5A;
    tx_valid = 1'b1;
    for (int i = 7; i >= 0; i--) exp_bits.push_back(tx_data[i]);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(bit_end == 1 && out_en == 1, "R6 coincident write", {bit_end, out_en}, 3);
    wait_idle();
    chk(falls == f0 + 1, "R6 coincident no gap", falls - f0, 1);
  endtask

  task automatic t_reset_mid();
    int b0;
    int guard = 0;
    send_byte(8'h96);
    send_byte(8'h55);
    b0 = bits_seen;
    while (bits_seen < b0 + 3 && guard < 20000) begin @(negedge clk); guard++; end
    pulse_reset(1'b0, 8'h00);
    chk(out_en == 0 && sample_out == 0, "R9 abort", {out_en, sample_out}, 0);
    chk(tx_ready == 1, "R9 buffer cleared", tx_ready, 1);
    repeat (3 * SPB * 4) @(negedge clk);
    chk(out_en == 0, "R9 stays released", out_en, 0);
    t_single(8'h81);
  endtask

  task automatic t_reset_with_write();
    pulse_reset(1'b1, 8'hF0);
    chk(tx_ready == 1, "R9 write dropped", tx_ready, 1);
    repeat (2 * SPB * 4) @(negedge clk);
    chk(out_en == 0, "R9 no start", out_en, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_single(8'hFF);
    t_single(8'h00);
    t_back_to_back();
    t_write_on_last_tick();
    chk(smax == AMP, "R11 positive peak", smax, AMP);
    chk(smin == -AMP, "R11 negative peak", smin, -AMP);
    t_reset_mid();
    t_reset_with_write();
    t_single(8'h6E);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule